// File: doc/BRIEF.md
# Grouped Register Write-Protection Unit

This unit stands between a register bus and a peripheral's register file and decides, write by write, whether a store may reach its target. The protectable registers are sorted into six groups. Each group carries two independent protection flags. The first is a software lock that software can set and release. The second is a hardware lock that software can set but can never release; only a reset of the unit clears it. A group is locked while either flag is up.

Software drives the flags through one control register. A control write carries a command code and a six-bit group mask, and the command acts only on the groups whose mask bit is 1. Every write aimed at a mapped register raises the matching bit of a one-hot write-enable gate, unless its group is locked. When the group is locked, the write is suppressed and the unit records a violation together with the word offset of the target. A status word shows both flag sets and the violation record. A read of the status register clears the violation record.

Top module: `wprot_guard`

## Requirements
- R1: After reset, all software flags, all hardware flags, the violation flag and the captured offset are zero, so `stat_word` reads 0.
- R2: A write to the control register (byte address 0xA0, word offset 40) takes its command from `wr_data[1:0]` and its group mask from `wr_data[13:8]`. It changes only the masked groups, and the result shows in `stat_word` one cycle later. The control register itself is never protected.
- R3: Command 0 clears the software flag of each masked group and command 1 sets it. Command 3 changes no flag.
- R4: Command 2 sets the hardware flag of each masked group. No command clears a hardware flag; only reset does.
- R5: A group is locked while its software flag or its hardware flag is set. A write to a register of a locked group leaves every `reg_wen` bit at 0.
- R6: A write to a mapped register of an unlocked group raises exactly that register's `reg_wen` bit in the same cycle. A write to an unmapped address, the control register or the status register raises no `reg_wen` bit and records no violation.
- R7: A blocked write sets the violation flag one cycle later and captures `wr_addr[7:2]`. A later blocked write replaces the captured offset.
- R8: A read of the status register (`rd_en` with byte address 0xA4, word offset 41) clears the violation flag and the captured offset one cycle later. If a blocked write occurs in the same cycle as the read, the new violation is kept.
- R9: The layout of `stat_word` is: bits [5:0] software flags, bits [11:6] hardware flags, bit [12] violation flag, bits [18:13] captured word offset. Bit n of each flag field belongs to group n.
- R10: The default map places registers 0..11 at word offsets 4..15. Register i belongs to group i/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data, decoded only for control writes |
| wr_en | input | 1 | Write strobe |
| rd_addr | input | 8 | Byte address of the read |
| rd_en | input | 1 | Read strobe |
| reg_wen | output | 12 | Per-register write-enable gate, one-hot or zero |
| stat_word | output | 19 | Flag state and violation record |

## Verification
The bench builds the unit with its default parameters: six groups, twelve registers at word offsets 4..15 with two per group, and control and status at offsets 40 and 41. Because the read and write addresses are separate, a status read and a blocked write can land in the same cycle, which exercises the priority of the new violation. The random mix mostly issues software commands and only rarely hardware locks. Together with a reset in the middle of the run, this keeps locked and unlocked groups in play all through the run, and it also confirms that reset alone removes the hardware locks.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  // Command codes carried in the control write
  typedef enum logic [1:0] {
    CMD_SW_CLEAR = 2'd0,
    CMD_SW_SET   = 2'd1,
    CMD_HW_SET   = 2'd2,
    CMD_NONE     = 2'd3
  } wp_cmd_e;

  // Field positions inside the control write data
  localparam int CMD_LSB  = 0;
  localparam int MASK_LSB = 8;

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode #(
  parameter int NREG   = 12,
  parameter int NGRP   = 6,
  parameter int WOFS_W = 6,
  parameter int GRP_W  = 3,
  parameter logic [NREG*WOFS_W-1:0] REG_WOFS = '0,
  parameter logic [NREG*GRP_W-1:0]  REG_GRP  = '0,
  parameter logic [WOFS_W-1:0] CTRL_WOFS = '0,
  parameter logic [WOFS_W-1:0] STAT_WOFS = '0
) (
  input  logic [WOFS_W-1:0] wr_wofs,
  input  logic [WOFS_W-1:0] rd_wofs,
  input  logic [NGRP-1:0]   grp_lock,
  output logic [NREG-1:0]   reg_hit,
  output logic [NREG-1:0]   reg_lock,
  output logic              ctrl_hit,
  output logic              stat_hit
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [GRP_W-1:0] GSEL = REG_GRP[i*GRP_W +: GRP_W];
    assign reg_hit[i]  = (wr_wofs == REG_WOFS[i*WOFS_W +: WOFS_W]);
    assign reg_lock[i] = grp_lock[GSEL];
  end

  assign ctrl_hit = (wr_wofs == CTRL_WOFS);
  assign stat_hit = (rd_wofs == STAT_WOFS);

  // R10: the map must never let two registers share an offset
  always_comb begin
    a_r10_unique_map: assert ($onehot0(reg_hit));
  end

endmodule

// File: rtl/wprot_flags.sv
module wprot_flags
  import wprot_pkg::*;
#(
  parameter int NGRP = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  wp_cmd_e         cmd,
  input  logic [NGRP-1:0] mask,
  output logic [NGRP-1:0] sw_q,
  output logic [NGRP-1:0] hw_q
);

  logic [NGRP-1:0] sw_d, hw_d;
  logic            flag_en;

  assign flag_en = cmd_valid;

  always_comb begin
    sw_d = sw_q;
    hw_d = hw_q;
    unique case (cmd)
      CMD_SW_CLEAR: sw_d = sw_q & ~mask;
      CMD_SW_SET:   sw_d = sw_q | mask;
      CMD_HW_SET:   hw_d = hw_q | mask;
      CMD_NONE:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= '0;
      hw_q <= '0;
    end else if (flag_en) begin
      sw_q <= sw_d;
      hw_q <= hw_d;
    end
  end

  a_r4_hw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_q & $past(hw_q)) == $past(hw_q)));

  a_r3_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_NONE) |=> ($stable(sw_q) && $stable(hw_q)));

  a_r3_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_SW_SET) |=> ((sw_q & $past(mask)) == $past(mask)));

  a_r2_unmasked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (((sw_q ^ $past(sw_q)) & ~$past(mask)) == '0));

endmodule

// File: rtl/wprot_viol.sv
module wprot_viol #(
  parameter int WOFS_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              viol_now,
  input  logic [WOFS_W-1:0] viol_wofs,
  input  logic              stat_rd,
  output logic              viol_q,
  output logic [WOFS_W-1:0] vofs_q
);

  logic              viol_d;
  logic [WOFS_W-1:0] vofs_d;
  logic              viol_en;

  assign viol_en = viol_now | stat_rd;

  always_comb begin
    if (viol_now) begin
      viol_d = 1'b1;
      vofs_d = viol_wofs;
    end else begin
      viol_d = 1'b0;
      vofs_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      vofs_q <= '0;
    end else if (viol_en) begin
      viol_q <= viol_d;
      vofs_q <= vofs_d;
    end
  end

  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> (viol_q && vofs_q == $past(viol_wofs)));

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !viol_now) |=> (!viol_q && vofs_q == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !viol_now) |=> ($stable(viol_q) && $stable(vofs_q)));

endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NGRP   = 6,
  parameter int NREG   = 12,
  parameter int GRP_W  = $clog2(NGRP),
  parameter logic [NREG*(ADDR_W-2)-1:0] REG_WOFS = {
    6'd15, 6'd14, 6'd13, 6'd12, 6'd11, 6'd10,
    6'd9,  6'd8,  6'd7,  6'd6,  6'd5,  6'd4},
  parameter logic [NREG*GRP_W-1:0] REG_GRP = {
    3'd5, 3'd5, 3'd4, 3'd4, 3'd3, 3'd3,
    3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0},
  parameter logic [ADDR_W-3:0] CTRL_WOFS = 6'd40,
  parameter logic [ADDR_W-3:0] STAT_WOFS = 6'd41,
  localparam int WOFS_W = ADDR_W - 2,
  localparam int STAT_W = 2*NGRP + 1 + WOFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [NREG-1:0]   reg_wen,
  output logic [STAT_W-1:0] stat_word
);

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NGRP-1:0]   sw_q, hw_q, grp_lock;
  logic [NREG-1:0]   reg_hit, reg_lock;
  logic              ctrl_hit, stat_hit;
  logic              viol_now, stat_rd, cmd_valid;
  logic              viol_q;
  logic [WOFS_W-1:0] vofs_q;
  wp_cmd_e           cmd;
  logic [NGRP-1:0]   mask;

  assign grp_lock = sw_q | hw_q;

  wprot_decode #(
    .NREG(NREG), .NGRP(NGRP), .WOFS_W(WOFS_W), .GRP_W(GRP_W),
    .REG_WOFS(REG_WOFS), .REG_GRP(REG_GRP),
    .CTRL_WOFS(CTRL_WOFS), .STAT_WOFS(STAT_WOFS)
  ) u_decode (
    .wr_wofs (wr_addr[ADDR_W-1:2]),
    .rd_wofs (rd_addr[ADDR_W-1:2]),
    .grp_lock(grp_lock),
    .reg_hit (reg_hit),
    .reg_lock(reg_lock),
    .ctrl_hit(ctrl_hit),
    .stat_hit(stat_hit)
  );

  assign cmd_valid = wr_en & ctrl_hit;
  assign cmd       = wp_cmd_e'(wr_data[CMD_LSB +: 2]);
  assign mask      = wr_data[MASK_LSB +: NGRP];

  wprot_flags #(.NGRP(NGRP)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cmd_valid(cmd_valid),
    .cmd      (cmd),
    .mask     (mask),
    .sw_q     (sw_q),
    .hw_q     (hw_q)
  );

  assign reg_wen  = wr_en ? (reg_hit & ~reg_lock) : '0;
  assign viol_now = wr_en & |(reg_hit & reg_lock);
  assign stat_rd  = rd_en & stat_hit;

  wprot_viol #(.WOFS_W(WOFS_W)) u_viol (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .viol_now (viol_now),
    .viol_wofs(wr_addr[ADDR_W-1:2]),
    .stat_rd  (stat_rd),
    .viol_q   (viol_q),
    .vofs_q   (vofs_q)
  );

  assign stat_word = {vofs_q, viol_q, hw_q, sw_q};

  a_r5_block: assert property (@(posedge clk) disable iff (!rst_n_s)
    viol_now |-> (reg_wen == '0));

  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(reg_wen));

  a_r6_ctrl_free: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_valid |-> (!viol_now && reg_wen == '0));

endmodule

// File: tb/wprot_guard_test.sv
module wprot_guard_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic        wr_en, rd_en;
  logic [11:0] reg_wen;
  logic [18:0] stat_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model
  logic [5:0] m_sw, m_hw;
  logic       m_viol;
  logic [5:0] m_vofs;

  always #5 clk = ~clk;

  wprot_guard uut (
    .clk(clk), .rst_n(rst_n),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_addr(rd_addr), .rd_en(rd_en),
    .reg_wen(reg_wen), .stat_word(stat_word)
  );

  function automatic bit mapped(input logic [7:0] a);
    return (a[7:2] >= 6'd4) && (a[7:2] <= 6'd15);
  endfunction

  function automatic int grp_of(input logic [7:0] a);
    return (int'(a[7:2]) - 4) / 2;
  endfunction

  function automatic logic [11:0] exp_wen(input logic [7:0] a, input logic we);
    logic [11:0] w = '0;
    if (we && mapped(a) && !(m_sw[grp_of(a)] | m_hw[grp_of(a)]))
      w[int'(a[7:2]) - 4] = 1'b1;
    return w;
  endfunction

  function automatic logic [18:0] exp_stat();
    return {m_vofs, m_viol, m_hw, m_sw};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_sw = '0; m_hw = '0; m_viol = 1'b0; m_vofs = '0;
  endtask

  task automatic step(input logic [7:0] wa, input logic [31:0] wd, input logic we,
                      input logic [7:0] ra, input logic re,
                      input string wtag, input string stag);
    bit blocked, rdclr;
    @(negedge clk);
    wr_addr = wa; wr_data = wd; wr_en = we; rd_addr = ra; rd_en = re;
    #1;
    chk(wtag, {20'd0, reg_wen}, {20'd0, exp_wen(wa, we)});
    blocked = we && mapped(wa) && (m_sw[grp_of(wa)] | m_hw[grp_of(wa)]);
    rdclr   = re && (ra[7:2] == 6'd41);
    @(posedge clk);
    if (blocked) begin
      m_viol = 1'b1; m_vofs = wa[7:2];
    end else if (rdclr) begin
      m_viol = 1'b0; m_vofs = '0;
    end
    if (we && wa[7:2] == 6'd40) begin
      case (wd[1:0])
        2'd0: m_sw = m_sw & ~wd[13:8];
        2'd1: m_sw = m_sw | wd[13:8];
        2'd2: m_hw = m_hw | wd[13:8];
        default: ;
      endcase
    end
    #1;
    chk(stag, {13'd0, stat_word}, {13'd0, exp_stat()});
  endtask

  function automatic logic [31:0] ctrl(input logic [1:0] c, input logic [5:0] m);
    return {18'd0, m, 6'd0, c};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset status", {13'd0, stat_word}, 32'd0);

    // R2/R3: software lock on group 1, then a blocked write
    step(8'hA0, ctrl(2'd1, 6'b000010), 1, 8'h00, 0, "R6 ctrl no wen", "R2 sw set g1");
    chk("R9 sw field", {26'd0, stat_word[5:0]}, 32'h2);
    step(8'h18, 32'hFFFF, 1, 8'h00, 0, "R5 locked wen", "R7 capture");
    chk("R9 vofs field", {26'd0, stat_word[18:13]}, 32'd6);
    step(8'h10, 32'h1, 1, 8'h00, 0, "R10 reg0 free", "R6 no viol change");
    step(8'h1C, 32'h1, 1, 8'h00, 0, "R5 locked reg3", "R7 overwrite");
    step(8'h00, 32'h0, 0, 8'hA4, 1, "R6 idle", "R8 read clear");
    // same-cycle violation and read
    step(8'h18, 32'h1, 1, 8'hA4, 1, "R5 locked", "R8 new kept");
    step(8'h50, 32'h1, 1, 8'hA4, 1, "R6 ungrouped", "R8 clear again");
    // reserved command
    step(8'hA0, ctrl(2'd3, 6'b111111), 1, 8'h00, 0, "R6 ctrl", "R3 reserved");
    step(8'hA0, ctrl(2'd0, 6'b000010), 1, 8'h00, 0, "R6 ctrl", "R3 sw clear");
    // hardware lock on group 5, cannot be cleared by command
    step(8'hA0, ctrl(2'd2, 6'b100000), 1, 8'h00, 0, "R6 ctrl", "R4 hw set");
    step(8'hA0, ctrl(2'd0, 6'b111111), 1, 8'h00, 0, "R6 ctrl", "R4 hw sticky");
    step(8'h3C, 32'h1, 1, 8'h00, 0, "R5 hw locked", "R7 hw capture");
    step(8'hA4, 32'h1, 1, 8'h00, 0, "R6 status addr", "R6 no viol");
    do_reset();
    #1;
    chk("R4 reset clears hw", {13'd0, stat_word}, 32'd0);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int kind;
      logic [7:0]  wa, ra;
      logic [31:0] wd;
      logic        we, re;
      logic [1:0]  c;
      string wt, st;
      kind = int'($urandom % 10);
      wa = 8'h00; wd = 32'd0; we = 0;
      ra = ($urandom % 3 == 0) ? 8'hA4 : 8'($urandom);
      re = ($urandom % 4 == 0);
      wt = "R6 wen"; st = "R9 status";
      if (kind <= 2) begin
        c = 2'($urandom);
        if (c == 2'd2 && ($urandom % 8 != 0)) c = 2'd1;
        wa = 8'hA0; wd = ctrl(c, 6'($urandom)); we = 1;
        st = (c == 2'd2) ? "R4 hw cmd" : "R3 sw cmd";
      end else if (kind <= 6) begin
        wa = 8'(16 + ($urandom % 48)); wd = $urandom; we = 1;
        if (m_sw[grp_of(wa)] | m_hw[grp_of(wa)]) begin
          wt = "R5 locked"; st = "R7 capture";
        end
      end else if (kind == 7) begin
        wa = 8'($urandom); wd = $urandom; we = 1;
        if (wa[7:2] == 6'd40) wa = 8'hA8;
      end else if (kind == 8) begin
        ra = 8'hA4; re = 1; st = "R8 read";
      end
      step(wa, wd, we, ra, re, wt, st);
      if (it == 1500) begin
        do_reset();
        #1;
        chk("R1 mid reset", {13'd0, stat_word}, 32'd0);
      end
    end

    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule